// File: doc/BRIEF.md
# Serial Clock-Calendar Register Port

This block is the bus-facing half of a clock-calendar: a two-wire serial slave that runs from a faster system clock and decodes a 10-entry register space. Entries 0 to 6 are the seven time and date bytes. Entry 7 is a control byte. Entry 8 is a charger-select byte. Entry 9 is a status byte that holds the oscillator-stopped bit.

The calendar counters live outside the block. They present their live values on a flat input bus. They receive writes as one-cycle strobes, one per time field, with a shared data byte. Reads of the time bytes come from a local shadow copy, so a multi-byte read sees one coherent instant even if the counters move part-way through. The shadow copy is refreshed on each START, on each STOP, and whenever the register pointer wraps to entry 0.

The control byte drives a test output. When the frequency-test bit is set, that output carries a 512 Hz tick. When it is clear, the output follows the output-level bit. Any write to the control byte also sends a one-cycle reset pulse to the external divider chain. The charger outputs are active only when the charger byte holds the 4-bit enabling key together with valid diode and resistor codes.

Top module: `rtc_i2c_regif`

## Requirements
- R1: The address byte is 7-bit device address 1101000 followed by a direction bit (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low. A non-matching address gets no acknowledge, and the rest of that transfer is ignored: no acknowledge and no register write.
- R2: In a write transfer, the first byte after the address loads the register pointer from its low four bits. Each following byte is acknowledged, stored at the pointer, and then the pointer increments.
- R3: When the pointer increments from 07h it goes to 00h, and when it increments from 09h it goes to 00h. Entries 08h and 09h are reached only by loading the pointer, so a write burst that starts at 08h continues into 09h and then into 00h.
- R4: Time bytes are read from a shadow copy of the live time bus. The copy is taken on START, on STOP, and when the pointer wraps to 00h. Live changes after the copy is taken are not seen until the next such event.
- R5: A read transfer starts at the pointer left by earlier accesses and sends bytes MSB first. The pointer increments after each byte. After the master answers a byte with NACK, the slave releases SDA and sends nothing further.
- R6: A data byte written to entries 0 to 6 produces exactly one one-cycle strobe on the bit of time_wr_stb_o that matches the entry index, and the byte appears on time_wr_data_o in that same cycle. At most one strobe bit is high at a time.
- R7: Status bit 7 is 1 after reset and is set by an osc_stop_i pulse. A write can clear it to 0, but a write of 1 leaves it unchanged. Status bits 6 to 0 always read 0.
- R8: The charger byte resets to 00h. chg_en_o is high only when bits 7:4 equal 1010, bits 3:2 are 01 or 10, and bits 1:0 are not 00. When chg_en_o is high, chg_diode_o is high for diode code 10 and chg_res_o equals bits 1:0; otherwise both are 0.
- R9: The control byte resets to 80h. test_out_o follows tick512_i when control bit 6 is 1, and equals control bit 7 when bit 6 is 0. The control and charger bytes read back as written.
- R10: Each write to entry 07h produces a single one-cycle pulse on div_rst_o.
- R11: A START at any point, including in the middle of a byte, restarts address reception. A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Drive SDA low when 1 (open drain) |
| time_live_i | input | 56 | Live time bytes, entry k in bits 8k+7:8k |
| time_wr_stb_o | output | 7 | One-cycle write strobe per time entry |
| time_wr_data_o | output | 8 | Data byte for the active strobe |
| div_rst_o | output | 1 | One-cycle divider reset on control write |
| osc_stop_i | input | 1 | Pulse reporting an oscillator stop |
| tick512_i | input | 1 | 512 Hz test waveform |
| test_out_o | output | 1 | Test pin level |
| chg_en_o | output | 1 | Charger enabled |
| chg_diode_o | output | 1 | Series diode selected |
| chg_res_o | output | 2 | Resistor select code |

## Verification
The hardest case to reach is a wrap that happens in the middle of a read. The shadow copy must still hold the values taken at START for entry 6, and must take a fresh copy for entry 0 after the pointer passes the control byte. The bench loads the pointer with 6 and issues a repeated START for reading. It changes the live time bus after the address byte, then reads three bytes. It expects the old entry 6, the control byte, and the new entry 0. A START in the middle of a byte is forced by clocking four data bits and then issuing a repeated START before the byte completes.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK_A, ST_RX, ST_ACK_W, ST_TX, ST_RACK
    } bus_st_e;

    localparam logic [6:0] DEV_ADDR = 7'b1101000;
    localparam int REG_CTRL = 7;
    localparam int REG_CHG  = 8;
    localparam int REG_FLAG = 9;
    localparam logic [3:0] CHG_KEY = 4'b1010;
endpackage

// File: rtl/rtc_i2c_line_det.sv
module rtc_i2c_line_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } det_s;

    det_s q, d;
    logic scl_s;

    assign scl_s = q.scl_sh[STAGES-1];
    assign sda_s = q.sda_sh[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_regif_pkg::*;
#(
    parameter int NUM_TIME = 7,
    parameter int DW       = 8,
    parameter int PW       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_TIME*DW-1:0] time_live_i,
    input  logic                   snap_req,
    input  logic                   ptr_ld,
    input  logic [PW-1:0]          ptr_val,
    input  logic                   wr_en,
    input  logic                   ptr_inc,
    input  logic [DW-1:0]          wr_data,
    input  logic                   osc_stop_i,
    input  logic                   tick512_i,
    output logic [DW-1:0]          rd_data,
    output logic [NUM_TIME-1:0]    time_wr_stb_o,
    output logic [DW-1:0]          time_wr_data_o,
    output logic                   div_rst_o,
    output logic                   test_out_o,
    output logic                   chg_en_o,
    output logic                   chg_diode_o,
    output logic [1:0]             chg_res_o
);
    localparam int IW = $clog2(NUM_TIME);
    localparam logic [PW-1:0] P_CTRL = PW'(REG_CTRL);
    localparam logic [PW-1:0] P_CHG  = PW'(REG_CHG);
    localparam logic [PW-1:0] P_FLAG = PW'(REG_FLAG);
    localparam logic [PW-1:0] P_NT   = PW'(NUM_TIME);

    typedef struct packed {
        logic [PW-1:0]                ptr;
        logic [NUM_TIME-1:0][DW-1:0]  snap;
        logic [DW-1:0]                ctrl;
        logic [DW-1:0]                chg;
        logic                         osf;
        logic [NUM_TIME-1:0]          stb;
        logic [DW-1:0]                wdata;
        logic                         divrst;
    } rf_s;

    rf_s q, d;
    logic wrap;
    logic key_ok, ds_ok, rout_ok;

    assign wrap = ptr_inc && (q.ptr == P_CTRL || q.ptr >= P_FLAG);

    always_comb begin
        d        = q;
        d.stb    = '0;
        d.divrst = 1'b0;
        if (snap_req || wrap) d.snap = time_live_i;
        if (wr_en) begin
            if (q.ptr < P_NT) begin
                d.stb[q.ptr[IW-1:0]] = 1'b1;
                d.wdata              = wr_data;
            end else if (q.ptr == P_CTRL) begin
                d.ctrl   = wr_data;
                d.divrst = 1'b1;
            end else if (q.ptr == P_CHG) begin
                d.chg = wr_data;
            end else if (q.ptr == P_FLAG) begin
                d.osf = q.osf & wr_data[DW-1];
            end
        end
        if (osc_stop_i) d.osf = 1'b1;
        if (ptr_ld) d.ptr = ptr_val;
        else if (ptr_inc) d.ptr = wrap ? '0 : q.ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= DW'(8'h80);
            q.osf  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (q.ptr < P_NT)        rd_data = q.snap[q.ptr[IW-1:0]];
        else if (q.ptr == P_CTRL) rd_data = q.ctrl;
        else if (q.ptr == P_CHG)  rd_data = q.chg;
        else if (q.ptr == P_FLAG) rd_data = {q.osf, {(DW-1){1'b0}}};
    end

    assign key_ok  = q.chg[7:4] == CHG_KEY;
    assign ds_ok   = q.chg[3] ^ q.chg[2];
    assign rout_ok = |q.chg[1:0];

    assign chg_en_o       = key_ok & ds_ok & rout_ok;
    assign chg_diode_o    = chg_en_o & q.chg[3];
    assign chg_res_o      = chg_en_o ? q.chg[1:0] : 2'b00;
    assign time_wr_stb_o  = q.stb;
    assign time_wr_data_o = q.wdata;
    assign div_rst_o      = q.divrst;
    assign test_out_o     = q.ctrl[6] ? tick512_i : q.ctrl[7];

    // R6
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(time_wr_stb_o));

    // R10
    divrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst_o |=> !div_rst_o);

    // R7
    osf_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.osf && !osc_stop_i) |=> !q.osf);

    // R3
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_ld && (q.ptr == P_CTRL || q.ptr == P_FLAG)) |=> q.ptr == '0);
endmodule

// File: rtl/rtc_i2c_regif.sv
module rtc_i2c_regif
    import rtc_regif_pkg::*;
#(
    parameter int NUM_TIME    = 7,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [NUM_TIME*DW-1:0] time_live_i,
    output logic [NUM_TIME-1:0]    time_wr_stb_o,
    output logic [DW-1:0]          time_wr_data_o,
    output logic                   div_rst_o,
    input  logic                   osc_stop_i,
    input  logic                   tick512_i,
    output logic                   test_out_o,
    output logic                   chg_en_o,
    output logic                   chg_diode_o,
    output logic [1:0]             chg_res_o
);
    localparam int PW = 4;
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] BITS_FULL = CW'(DW);
    localparam logic [CW-1:0] BITS_LAST = CW'(DW - 1);

    typedef struct packed {
        bus_st_e       st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [DW-1:0] tx;
        logic          rw;
        logic          first;
        logic          mack;
        logic          sda_oe;
    } fsm_s;

    fsm_s q, d;
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ptr_ld, wr_en, ptr_inc;
    logic [DW-1:0] rd_data;

    rtc_i2c_line_det #(.STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    always_comb begin
        d       = q;
        ptr_ld  = 1'b0;
        wr_en   = 1'b0;
        ptr_inc = 1'b0;
        if (start_det) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
        end else if (stop_det) begin
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DW-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS_FULL) begin
                        d.cnt = '0;
                        if (q.sh[DW-1:1] == DEV_ADDR) begin
                            d.sda_oe = 1'b1;
                            d.rw     = q.sh[0];
                            d.st     = ST_ACK_A;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK_A: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.tx     = rd_data;
                            d.sda_oe = ~rd_data[DW-1];
                            d.st     = ST_TX;
                        end else begin
                            d.sda_oe = 1'b0;
                            d.first  = 1'b1;
                            d.st     = ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DW-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS_FULL) begin
                        d.cnt    = '0;
                        d.sda_oe = 1'b1;
                        d.st     = ST_ACK_W;
                        d.first  = 1'b0;
                        if (q.first) begin
                            ptr_ld = 1'b1;
                        end else begin
                            wr_en   = 1'b1;
                            ptr_inc = 1'b1;
                        end
                    end
                end
                ST_ACK_W: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.st     = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == BITS_LAST) begin
                            d.sda_oe = 1'b0;
                            d.cnt    = '0;
                            d.st     = ST_RACK;
                            ptr_inc  = 1'b1;
                        end else begin
                            d.cnt    = q.cnt + 1'b1;
                            d.tx     = {q.tx[DW-2:0], 1'b0};
                            d.sda_oe = ~q.tx[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.tx     = rd_data;
                            d.sda_oe = ~rd_data[DW-1];
                            d.st     = ST_TX;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.sda_oe;

    rtc_regfile #(.NUM_TIME(NUM_TIME), .DW(DW), .PW(PW)) u_rf (
        .clk(clk), .rst_n(rst_n), .time_live_i(time_live_i),
        .snap_req(start_det | stop_det), .ptr_ld(ptr_ld),
        .ptr_val(q.sh[PW-1:0]), .wr_en(wr_en), .ptr_inc(ptr_inc),
        .wr_data(q.sh), .osc_stop_i(osc_stop_i), .tick512_i(tick512_i),
        .rd_data(rd_data), .time_wr_stb_o(time_wr_stb_o),
        .time_wr_data_o(time_wr_data_o), .div_rst_o(div_rst_o),
        .test_out_o(test_out_o), .chg_en_o(chg_en_o),
        .chg_diode_o(chg_diode_o), .chg_res_o(chg_res_o)
    );

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

// File: tb/rtc_i2c_regif_tb.sv
module rtc_i2c_regif_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [55:0] time_live = '0;
    logic [6:0] time_wr_stb;
    logic [7:0] time_wr_data;
    logic div_rst, osc_stop = 1'b0, tick512 = 1'b0, test_out;
    logic chg_en, chg_diode;
    logic [1:0] chg_res;

    int checks = 0, errors = 0;
    int stb_cnt = 0, div_cnt = 0;
    logic [6:0] last_stb = '0;
    logic [7:0] last_wdata = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    rtc_i2c_regif u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .time_live_i(time_live), .time_wr_stb_o(time_wr_stb),
        .time_wr_data_o(time_wr_data), .div_rst_o(div_rst),
        .osc_stop_i(osc_stop), .tick512_i(tick512), .test_out_o(test_out),
        .chg_en_o(chg_en), .chg_diode_o(chg_diode), .chg_res_o(chg_res)
    );

    always @(negedge clk) begin
        if (rst_n && |time_wr_stb) begin
            stb_cnt++;
            last_stb   = time_wr_stb;
            last_wdata = time_wr_data;
        end
        if (rst_n && div_rst) div_cnt++;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (QH) @(posedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half(); half();
        sda_m = 1'b0; half(); half();
        scl_m = 1'b0; half();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half(); half();
        sda_m = 1'b1; half(); half();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; half();
        scl_m = 1'b1; half(); half();
        scl_m = 1'b0; half();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        ack = ~sda_bus;
        half();
        scl_m = 1'b0; half();
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            half();
            scl_m = 1'b1; half();
            b = {b[6:0], sda_bus};
            half();
            scl_m = 1'b0; half();
        end
        send_bit(~mack);
        sda_m = 1'b1;
    endtask

    task automatic wr_reg(input logic [7:0] ptr, input logic [7:0] val);
        logic a;
        i2c_start(); wr_byte(8'hD0, a); wr_byte(ptr, a); wr_byte(val, a); i2c_stop();
    endtask

    task automatic rd_reg(input logic [7:0] ptr, output logic [7:0] val);
        logic a;
        i2c_start(); wr_byte(8'hD0, a); wr_byte(ptr, a);
        i2c_start(); wr_byte(8'hD1, a); rd_byte(1'b0, val); i2c_stop();
    endtask

    task automatic t_reset();
        chk("R9 reset test_out", {7'b0, test_out}, 8'h01);
        chk("R8 reset chg_en", {7'b0, chg_en}, 8'h00);
        chk("R11 reset sda_oe", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_flag_reset();
        logic [7:0] v;
        rd_reg(8'h09, v);
        chk("R7 status after reset", v, 8'h80);
    endtask

    task automatic t_bad_addr();
        logic a;
        int n0 = stb_cnt;
        i2c_start(); wr_byte(8'hA0, a);
        chk("R1 foreign address no ack", {7'b0, a}, 8'h00);
        wr_byte(8'h00, a); wr_byte(8'h55, a); i2c_stop();
        chk("R1 foreign transfer writes nothing", 8'(stb_cnt - n0), 8'h00);
    endtask

    task automatic t_write_time();
        logic a;
        int n0 = stb_cnt;
        i2c_start(); wr_byte(8'hD0, a);
        chk("R1 own address ack", {7'b0, a}, 8'h01);
        wr_byte(8'h00, a);
        chk("R2 pointer byte ack", {7'b0, a}, 8'h01);
        wr_byte(8'h45, a);
        chk("R6 strobe entry 0", {1'b0, last_stb}, 8'h01);
        chk("R6 data entry 0", last_wdata, 8'h45);
        wr_byte(8'h12, a);
        chk("R2 second data ack", {7'b0, a}, 8'h01);
        chk("R2 pointer advanced to entry 1", {1'b0, last_stb}, 8'h02);
        chk("R6 data entry 1", last_wdata, 8'h12);
        i2c_stop();
        chk("R6 one strobe per byte", 8'(stb_cnt - n0), 8'h02);
    endtask

    task automatic t_read_from_ptr();
        logic a;
        logic [7:0] v;
        for (int k = 0; k < 7; k++) time_live[8*k +: 8] = 8'h10 + 8'(k);
        i2c_start(); wr_byte(8'hD0, a); wr_byte(8'h03, a); i2c_stop();
        i2c_start(); wr_byte(8'hD1, a);
        rd_byte(1'b1, v); chk("R5 read starts at pointer", v, 8'h13);
        rd_byte(1'b0, v); chk("R5 pointer advances on read", v, 8'h14);
        half(); half();
        chk("R5 SDA released after NACK", {7'b0, sda_oe}, 8'h00);
        i2c_stop();
    endtask

    task automatic t_snapshot_wrap();
        logic a;
        logic [7:0] v;
        for (int k = 0; k < 7; k++) time_live[8*k +: 8] = 8'h10 + 8'(k);
        i2c_start(); wr_byte(8'hD0, a); wr_byte(8'h06, a);
        i2c_start(); wr_byte(8'hD1, a);
        for (int k = 0; k < 7; k++) time_live[8*k +: 8] = 8'h50 + 8'(k);
        rd_byte(1'b1, v); chk("R4 shadow holds START copy", v, 8'h16);
        rd_byte(1'b1, v); chk("R9 control readback", v, 8'h80);
        rd_byte(1'b0, v); chk("R3 R4 wrap 07h to 00h refreshes shadow", v, 8'h50);
        i2c_stop();
    endtask

    task automatic t_control();
        int d0 = div_cnt;
        wr_reg(8'h07, 8'h40);
        chk("R10 one divider pulse", 8'(div_cnt - d0), 8'h01);
        tick512 = 1'b1; @(negedge clk);
        chk("R9 test_out follows tick high", {7'b0, test_out}, 8'h01);
        tick512 = 1'b0; @(negedge clk);
        chk("R9 test_out follows tick low", {7'b0, test_out}, 8'h00);
        wr_reg(8'h07, 8'h00);
        tick512 = 1'b1; @(negedge clk);
        chk("R9 test_out equals OUT=0", {7'b0, test_out}, 8'h00);
        wr_reg(8'h07, 8'h80);
        chk("R9 test_out equals OUT=1", {7'b0, test_out}, 8'h01);
        chk("R10 divider pulse per write", 8'(div_cnt - d0), 8'h03);
        tick512 = 1'b0;
    endtask

    task automatic t_charger();
        logic a;
        logic [7:0] v;
        wr_reg(8'h08, 8'hA5);
        chk("R8 key enables", {7'b0, chg_en}, 8'h01);
        chk("R8 no diode", {7'b0, chg_diode}, 8'h00);
        chk("R8 resistor code", {6'b0, chg_res}, 8'h01);
        wr_reg(8'h08, 8'hAA);
        chk("R8 diode selected", {7'b0, chg_diode}, 8'h01);
        chk("R8 resistor code 10", {6'b0, chg_res}, 8'h02);
        wr_reg(8'h08, 8'hA4);
        chk("R8 resistor 00 disables", {7'b0, chg_en}, 8'h00);
        wr_reg(8'h08, 8'hAD);
        chk("R8 diode 11 disables", {7'b0, chg_en}, 8'h00);
        wr_reg(8'h08, 8'hB5);
        chk("R8 wrong key disables", {7'b0, chg_en}, 8'h00);
        rd_reg(8'h08, v);
        chk("R9 charger readback", v, 8'hB5);
        i2c_start(); wr_byte(8'hD0, a); wr_byte(8'h08, a);
        wr_byte(8'hA9, a); wr_byte(8'hFF, a); wr_byte(8'h33, a);
        chk("R3 burst wraps 09h to entry 0", {1'b0, last_stb}, 8'h01);
        chk("R3 wrapped data", last_wdata, 8'h33);
        i2c_stop();
        chk("R8 burst write to charger", {7'b0, chg_en}, 8'h01);
        rd_reg(8'h09, v);
        chk("R7 write of 1 keeps status", v, 8'h80);
    endtask

    task automatic t_flag();
        logic [7:0] v;
        wr_reg(8'h09, 8'h7F);
        rd_reg(8'h09, v);
        chk("R7 clear by write, low bits zero", v, 8'h00);
        wr_reg(8'h09, 8'hFF);
        rd_reg(8'h09, v);
        chk("R7 write cannot set", v, 8'h00);
        @(negedge clk); osc_stop = 1'b1; @(negedge clk); osc_stop = 1'b0;
        rd_reg(8'h09, v);
        chk("R7 stop event sets", v, 8'h80);
    endtask

    task automatic t_mid_start();
        logic a;
        i2c_start(); wr_byte(8'hD0, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        i2c_start(); wr_byte(8'hD0, a);
        chk("R11 address after mid-byte START", {7'b0, a}, 8'h01);
        wr_byte(8'h02, a); wr_byte(8'h23, a);
        chk("R11 strobe after restart", {1'b0, last_stb}, 8'h04);
        chk("R11 data after restart", last_wdata, 8'h23);
        i2c_stop();
        half();
        chk("R11 idle after STOP", {7'b0, sda_oe}, 8'h00);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_flag_reset();
        t_bad_addr();
        t_write_time();
        t_read_from_ptr();
        t_snapshot_wrap();
        t_control();
        t_charger();
        t_flag();
        t_mid_start();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule